// File: doc/BRIEF.md
# NAND Flash Strobe Timing Generator

This block runs one bus cycle at a time on an asynchronous NAND flash port. A caller presents a request with a direction (read or write) and a type (command, address or data). The block then drives chip enable, the two latch enables, the read and write strobes and the data output enable. Every phase of the cycle lasts a programmable number of system clocks: a setup phase, a strobe pulse and a hold phase. Reads and writes each have their own three counts. Each count is taken from its input field only in the clock where the request is accepted.

On a read, the block captures the flash data bus on the clock edge that ends the read strobe pulse. That value stays on the read data output until the next read replaces it. On a write, the block drives the write data onto the bus through the setup and pulse phases and releases the bus when the hold phase begins. After each write strobe rises, the flash ready/busy line is ignored for a window. The window length is the write hold count plus twice a separate busy count. After that, a registered device-ready flag follows the line. A one-clock done pulse marks the end of every cycle.

Top module: `nand_strobe_gen`

## Requirements
- R1: During and right after reset: ceN, reN and weN are high; cleOut, aleOut, nandOe, done and devReady are low; reqReady is high.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both high. reqReady is high only while no cycle is in progress. ceN is low for exactly su+pw+hd clocks, starting in the clock after acceptance.
- R3: On a read (reqWrite=0), reN is low for exactly rdPw clocks. Before the pulse there are rdSu clocks with ceN low and reN high. After it there are rdHd clocks with ceN low and reN high. weN stays high for the whole read.
- R4: On a write (reqWrite=1), weN is low for exactly wrPw clocks. Before the pulse there are wrSu setup clocks, and after it there are wrHd hold clocks. reN stays high for the whole write.
- R5: A timing field of value 0 behaves as 1. Fields are sampled only on the accepting edge, so changing them during a cycle has no effect on that cycle.
- R6: For the whole cycle (every clock with ceN low), cleOut is high when reqKind was 0 (command) and aleOut is high when reqKind was 1 (address). Kinds 2 and 3 (data) leave both low.
- R7: nandOe is high only during the setup and pulse clocks of a write. While it is high, nandOut equals the accepted reqWdata. It is low during every read clock, every write hold clock and every idle clock.
- R8: rdData takes nandIn as sampled on the edge that ends the last reN-low clock. It keeps that value until a later read captures a new one.
- R9: done is high for exactly one clock: the clock after the final hold clock of each cycle.
- R10: devReady goes low on the edge that accepts a write. Let t0 be the first clock with weN high after the write pulse. nandRb is ignored in clocks t0 up to t0+L-1, where L = wrHd + 2*wrBusy (zero fields counted as 1). In every other clock where no write is pending before its hold phase, devReady takes nandRb on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request can be taken |
| reqWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| reqKind | input | 2 | 0 command, 1 address, 2/3 data |
| reqWdata | input | DATA_W | Write data |
| rdSu | input | FIELD_W | Read setup clocks |
| rdPw | input | FIELD_W | Read strobe width clocks |
| rdHd | input | FIELD_W | Read hold clocks |
| wrSu | input | FIELD_W | Write setup clocks |
| wrPw | input | FIELD_W | Write strobe width clocks |
| wrHd | input | FIELD_W | Write hold clocks |
| wrBusy | input | FIELD_W | Busy-window half length |
| nandIn | input | DATA_W | Data from flash |
| nandRb | input | 1 | Flash ready (1) / busy (0) |
| nandOut | output | DATA_W | Data to flash |
| nandOe | output | 1 | Data output enable |
| ceN | output | 1 | Chip enable, active low |
| cleOut | output | 1 | Command latch enable |
| aleOut | output | 1 | Address latch enable |
| reN | output | 1 | Read strobe, active low |
| weN | output | 1 | Write strobe, active low |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdData | output | DATA_W | Captured read data |
| devReady | output | 1 | Filtered ready/busy state |

## Verification
The bench targets zero-valued fields, which a design lacking the zero-as-one rule would turn into a 16-clock phase or a missing strobe. It also targets the largest fields, which catch a phase counter that wraps early. The timing fields and write data are changed right after acceptance, so a design that reads them live produces wrong strobe lengths or wrong bus data. Reads follow writes while the busy window is still open, and the longest window is 45 clocks. A design that starts the window at the wrong edge, or that uses the read hold count or a single busy count, updates devReady from the toggling ready line too early or too late. Each read has its own incrementing data pattern, so a capture one clock early or late returns a neighbouring value.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;       // request accepted this clock
    logic active;     // a cycle is in progress
    logic isWrite;    // current cycle direction
    logic inPulse;    // strobe pulse phase
    logic drive;      // write data on the bus
    logic capture;    // last read-strobe clock
    logic enterHold;  // last pulse clock (either direction)
    logic finish;     // last hold clock
  } ctl_s;

endpackage

// File: rtl/nsg_ctrl.sv
module nsg_ctrl
  import nsg_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [FIELD_W-1:0] rdSu,
  input  logic [FIELD_W-1:0] rdPw,
  input  logic [FIELD_W-1:0] rdHd,
  input  logic [FIELD_W-1:0] wrSu,
  input  logic [FIELD_W-1:0] wrPw,
  input  logic [FIELD_W-1:0] wrHd,
  output logic               reqReady,
  output ctl_s               ctl
);

  localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

  function automatic logic [FIELD_W-1:0] effLen(input logic [FIELD_W-1:0] f);
    return (f == '0) ? ONE : f;
  endfunction

  phase_e             phase;
  logic [FIELD_W-1:0] cnt;
  logic [FIELD_W-1:0] pwLat;
  logic [FIELD_W-1:0] hdLat;
  logic               isWrite;
  logic               accept;
  logic               cntZero;
  logic [FIELD_W-1:0] selSu;
  logic [FIELD_W-1:0] selPw;
  logic [FIELD_W-1:0] selHd;

  assign accept  = reqValid && (phase == PH_IDLE);
  assign cntZero = (cnt == '0);
  assign selSu   = reqWrite ? wrSu : rdSu;
  assign selPw   = reqWrite ? wrPw : rdPw;
  assign selHd   = reqWrite ? wrHd : rdHd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      pwLat   <= ONE;
      hdLat   <= ONE;
      isWrite <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase   <= PH_SETUP;
            isWrite <= reqWrite;
            cnt     <= effLen(selSu) - ONE;
            pwLat   <= effLen(selPw);
            hdLat   <= effLen(selHd);
          end
        end
        PH_SETUP: begin
          if (cntZero) begin
            phase <= PH_PULSE;
            cnt   <= pwLat - ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        PH_PULSE: begin
          if (cntZero) begin
            phase <= PH_HOLD;
            cnt   <= hdLat - ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        PH_HOLD: begin
          if (cntZero) begin
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load      = accept;
    ctl.active    = (phase != PH_IDLE);
    ctl.isWrite   = isWrite;
    ctl.inPulse   = (phase == PH_PULSE);
    ctl.drive     = isWrite && ((phase == PH_SETUP) || (phase == PH_PULSE));
    ctl.enterHold = (phase == PH_PULSE) && cntZero;
    ctl.capture   = (phase == PH_PULSE) && cntZero && !isWrite;
    ctl.finish    = (phase == PH_HOLD) && cntZero;
  end

  assign reqReady = (phase == PH_IDLE);

endmodule

// File: rtl/nsg_datapath.sv
module nsg_datapath
  import nsg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_s               ctl,
  input  logic               reqWrite,
  input  logic [1:0]         reqKind,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [FIELD_W-1:0] wrHd,
  input  logic [FIELD_W-1:0] wrBusy,
  input  logic [DATA_W-1:0]  nandIn,
  input  logic               nandRb,
  output logic [DATA_W-1:0]  nandOut,
  output logic               nandOe,
  output logic               ceN,
  output logic               cleOut,
  output logic               aleOut,
  output logic               reN,
  output logic               weN,
  output logic               done,
  output logic [DATA_W-1:0]  rdData,
  output logic               devReady
);

  // hold + 2*busy of 4-bit fields fits in two extra bits
  localparam int BLANK_W = FIELD_W + 2;
  localparam logic [FIELD_W-1:0] ONE   = FIELD_W'(1);
  localparam logic [BLANK_W-1:0] B_ONE = BLANK_W'(1);
  localparam logic [1:0] KIND_CMD  = 2'd0;
  localparam logic [1:0] KIND_ADDR = 2'd1;

  function automatic logic [FIELD_W-1:0] effLen(input logic [FIELD_W-1:0] f);
    return (f == '0) ? ONE : f;
  endfunction

  logic [1:0]         kindLat;
  logic [DATA_W-1:0]  wdataLat;
  logic [BLANK_W-1:0] blankLen;
  logic [BLANK_W-1:0] blankCnt;
  logic               wrPending;
  logic               sampleOk;
  logic               writeLoad;
  logic               writeHold;

  assign writeLoad = ctl.load && reqWrite;
  assign writeHold = ctl.enterHold && ctl.isWrite;
  assign sampleOk  = !wrPending && (blankCnt == '0);

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindLat  <= 2'd2;
      wdataLat <= '0;
      blankLen <= '0;
    end else if (ctl.load) begin
      kindLat  <= reqKind;
      wdataLat <= reqWdata;
      blankLen <= BLANK_W'(effLen(wrHd)) + (BLANK_W'(effLen(wrBusy)) << 1);
    end
  end

  // ready/busy filter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPending <= 1'b0;
      blankCnt  <= '0;
      devReady  <= 1'b0;
    end else begin
      if (writeLoad) begin
        wrPending <= 1'b1;
      end else if (writeHold) begin
        wrPending <= 1'b0;
      end

      if (writeHold) begin
        blankCnt <= blankLen;
      end else if (blankCnt != '0) begin
        blankCnt <= blankCnt - B_ONE;
      end

      if (writeLoad) begin
        devReady <= 1'b0;
      end else if (sampleOk) begin
        devReady <= nandRb;
      end
    end
  end

  // read capture and completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.capture) begin
        rdData <= nandIn;
      end
    end
  end

  assign ceN     = !ctl.active;
  assign reN     = !(ctl.inPulse && !ctl.isWrite);
  assign weN     = !(ctl.inPulse && ctl.isWrite);
  assign cleOut  = ctl.active && (kindLat == KIND_CMD);
  assign aleOut  = ctl.active && (kindLat == KIND_ADDR);
  assign nandOe  = ctl.drive;
  assign nandOut = wdataLat;

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [1:0]         reqKind,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [FIELD_W-1:0] rdSu,
  input  logic [FIELD_W-1:0] rdPw,
  input  logic [FIELD_W-1:0] rdHd,
  input  logic [FIELD_W-1:0] wrSu,
  input  logic [FIELD_W-1:0] wrPw,
  input  logic [FIELD_W-1:0] wrHd,
  input  logic [FIELD_W-1:0] wrBusy,
  input  logic [DATA_W-1:0]  nandIn,
  input  logic               nandRb,
  output logic [DATA_W-1:0]  nandOut,
  output logic               nandOe,
  output logic               ceN,
  output logic               cleOut,
  output logic               aleOut,
  output logic               reN,
  output logic               weN,
  output logic               done,
  output logic [DATA_W-1:0]  rdData,
  output logic               devReady
);

  ctl_s ctl;

  nsg_ctrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .rdSu     (rdSu),
    .rdPw     (rdPw),
    .rdHd     (rdHd),
    .wrSu     (wrSu),
    .wrPw     (wrPw),
    .wrHd     (wrHd),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  nsg_datapath #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqWrite (reqWrite),
    .reqKind  (reqKind),
    .reqWdata (reqWdata),
    .wrHd     (wrHd),
    .wrBusy   (wrBusy),
    .nandIn   (nandIn),
    .nandRb   (nandRb),
    .nandOut  (nandOut),
    .nandOe   (nandOe),
    .ceN      (ceN),
    .cleOut   (cleOut),
    .aleOut   (aleOut),
    .reN      (reN),
    .weN      (weN),
    .done     (done),
    .rdData   (rdData),
    .devReady (devReady)
  );

endmodule

// File: rtl/nsg_checker.sv
module nsg_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              ceN,
  input logic              cleOut,
  input logic              aleOut,
  input logic              reN,
  input logic              weN,
  input logic              nandOe,
  input logic              done,
  input logic [DATA_W-1:0] rdData,
  input logic              devReady
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (ceN && reN && weN && !nandOe)); // R2

  AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (!rstN)
    (!reN || !weN) |-> !ceN); // R3

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!reN && !weN)); // R4

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cleOut && aleOut)); // R6

  AST_BUS_FREE_READ: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> !nandOe); // R7

  AST_RDATA_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $past(!reN)); // R8

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_BUSY_DURING_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !devReady); // R10

endmodule

bind nand_strobe_gen nsg_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/nand_strobe_gen_tb.sv
`timescale 1ns/1ps
module nand_strobe_gen_tb;

  localparam int DATA_W  = 8;
  localparam int FIELD_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [1:0] reqKind = 2'd2;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [FIELD_W-1:0] rdSu = '0, rdPw = '0, rdHd = '0;
  logic [FIELD_W-1:0] wrSu = '0, wrPw = '0, wrHd = '0, wrBusy = '0;
  logic [DATA_W-1:0] nandIn = 8'h11;
  logic nandRb = 1'b0;
  logic reqReady, nandOe, ceN, cleOut, aleOut, reN, weN, done, devReady;
  logic [DATA_W-1:0] nandOut, rdData;

  int nChecks = 0;
  int nFails = 0;
  int cycle = 0;

  always #2.5 clk = ~clk;

  nand_strobe_gen #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cycle, act, exp);
    end
  endtask

  function automatic int eff(input logic [FIELD_W-1:0] f);
    return (f == 0) ? 1 : int'(f);
  endfunction

  // ---------------- behavioural reference ----------------
  bit mBusy, mWrite, mDone, mReady, mWrPend;
  int mK, mSu, mPw, mHd, mBlank, mLen, mKind;
  int mWdata, mRd;

  always @(posedge clk) begin
    int total;
    bit last, pulseEnd, allowed, acc;
    if (!rstN) begin
      mBusy = 0; mWrite = 0; mDone = 0; mReady = 0; mWrPend = 0;
      mK = 0; mSu = 1; mPw = 1; mHd = 1; mBlank = 0; mLen = 0; mKind = 2;
      mWdata = 0; mRd = 0;
    end else begin
      total    = mSu + mPw + mHd;
      last     = mBusy && (mK == total - 1);
      pulseEnd = mBusy && (mK == mSu + mPw - 1);
      allowed  = !mWrPend && (mBlank == 0);
      acc      = reqValid && !mBusy;
      mDone = last;
      if (pulseEnd && !mWrite) mRd = int'(nandIn);
      if (pulseEnd && mWrite) begin
        mWrPend = 0; mBlank = mLen;
      end else if (mBlank > 0) mBlank--;
      if (acc && reqWrite) begin
        mReady = 0; mWrPend = 1;
      end else if (allowed) mReady = nandRb;
      if (acc) begin
        mBusy = 1; mK = 0; mWrite = reqWrite; mKind = int'(reqKind);
        mWdata = int'(reqWdata);
        mSu = eff(reqWrite ? wrSu : rdSu);
        mPw = eff(reqWrite ? wrPw : rdPw);
        mHd = eff(reqWrite ? wrHd : rdHd);
        mLen = eff(wrHd) + 2 * eff(wrBusy);
      end else if (mBusy) begin
        if (last) mBusy = 0; else mK++;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    bit pulse, oeExp;
    if (rstN) begin
      pulse = mBusy && (mK >= mSu) && (mK < mSu + mPw);
      oeExp = mBusy && mWrite && (mK < mSu + mPw);
      chk("R2 reqReady", int'(reqReady), int'(!mBusy));
      chk("R2 ceN", int'(ceN), int'(!mBusy));
      chk("R3 R5 reN", int'(reN), int'(!(pulse && !mWrite)));
      chk("R4 R5 weN", int'(weN), int'(!(pulse && mWrite)));
      chk("R6 cleOut", int'(cleOut), int'(mBusy && mKind == 0));
      chk("R6 aleOut", int'(aleOut), int'(mBusy && mKind == 1));
      chk("R7 nandOe", int'(nandOe), int'(oeExp));
      if (oeExp) chk("R7 nandOut", int'(nandOut), mWdata);
      chk("R8 rdData", int'(rdData), mRd);
      chk("R9 done", int'(done), int'(mDone));
      chk("R10 devReady", int'(devReady), int'(mReady));
    end
  end

  // flash-side stimulus
  always @(negedge clk) begin
    cycle++;
    nandIn <= nandIn + 8'h3B;
    nandRb <= cycle[2] ^ cycle[4];
  end

  // watchdog
  always @(posedge clk) begin
    if (cycle > 20000) begin
      nFails++;
      $display("FAIL watchdog: actual cycle %0d expected below 20000", cycle);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  // issue one request; returns at the negedge after acceptance
  task automatic issue(input bit w, input logic [1:0] k, input logic [7:0] d,
                       input logic [3:0] su, input logic [3:0] pw,
                       input logic [3:0] hd, input logic [3:0] bz);
    reqValid = 1; reqWrite = w; reqKind = k; reqWdata = d;
    if (w) begin wrSu = su; wrPw = pw; wrHd = hd; end
    else begin rdSu = su; rdPw = pw; rdHd = hd; end
    wrBusy = bz;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    // scramble everything: must not affect the running cycle (R5)
    reqValid = 0; reqWrite = ~w; reqKind = ~k; reqWdata = ~d;
    rdSu = 4'hF; rdPw = 4'h0; rdHd = 4'hF;
    wrSu = 4'h0; wrPw = 4'hF; wrHd = 4'h0; wrBusy = 4'hF;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 ceN", int'(ceN), 1);
    chk("R1 reN", int'(reN), 1);
    chk("R1 weN", int'(weN), 1);
    chk("R1 cleOut", int'(cleOut), 0);
    chk("R1 aleOut", int'(aleOut), 0);
    chk("R1 nandOe", int'(nandOe), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 devReady", int'(devReady), 0);
    chk("R1 reqReady", int'(reqReady), 1);
    rstN = 1;
    idle(4);
    // command write, short timing
    issue(1, 2'd0, 8'hA5, 4'd1, 4'd2, 4'd1, 4'd1);
    waitDone(); idle(8);
    // address write, every field zero (R5)
    issue(1, 2'd1, 8'h3C, 4'd0, 4'd0, 4'd0, 4'd0);
    waitDone(); idle(2);
    // reads with assorted timing, back to back
    issue(0, 2'd2, 8'h00, 4'd3, 4'd4, 4'd2, 4'd0);
    issue(0, 2'd3, 8'h00, 4'd0, 4'd0, 4'd0, 4'd0);
    issue(0, 2'd2, 8'h00, 4'd2, 4'd1, 4'd5, 4'd0);
    waitDone(); idle(3);
    // longest write, then reads inside the busy window (R10)
    issue(1, 2'd2, 8'h5A, 4'd15, 4'd15, 4'd15, 4'd15);
    issue(0, 2'd0, 8'h00, 4'd1, 4'd1, 4'd1, 4'd0);
    issue(0, 2'd1, 8'h00, 4'd15, 4'd15, 4'd15, 4'd0);
    waitDone(); idle(50);
    // write followed directly by write, kind 3
    issue(1, 2'd3, 8'hC3, 4'd2, 4'd3, 4'd4, 4'd2);
    issue(1, 2'd0, 8'h81, 4'd1, 4'd1, 4'd1, 4'd7);
    issue(0, 2'd2, 8'h00, 4'd1, 4'd6, 4'd1, 4'd0);
    waitDone(); idle(40);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule